// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 64-word, 36-bit first-in first-out buffer placed between two clock domains that may run from unrelated or identical clocks. A producer on the write side stores one word on each rising write-clock edge that is qualified by an active-low select and an active-high enable. A consumer on the read side takes one word on each qualified rising read-clock edge. The word appears on a registered output after that edge.

Four active-low flags report the fill level. The write side has a full flag and an almost-full flag, both clocked by the write clock. The read side has an empty flag and an almost-empty flag, both clocked by the read clock. A single threshold X drives both "almost" flags. X is one of four preset values, and the two-bit select input chooses it at the moment reset is released. Pointers cross between the domains in Gray code. Each flag register acts as the second stage behind a single capture flop, so a flag moves on the second edge of its own clock after the event it reports.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: A write happens only on a rising `wr_clk` edge with `wr_cs_n`=0, `wr_en`=1 and `full_n`=1. A read happens only on a rising `rd_clk` edge with `rd_cs_n`=0, `rd_en`=1 and `empty_n`=1. Any other combination leaves the stored contents and the fill level unchanged.
- R2: Words leave in the order they were stored. `rd_data` takes the next word at the read edge that accepts a read, and it holds its value on every other read edge.
- R3: While `rst_n` is 0, `full_n`, `afull_n`, `empty_n` and `aempty_n` are all 0.
- R4: After `rst_n` rises, `full_n` is still 0 following the first `wr_clk` rising edge and is 1 following the second.
- R5: A word written into an empty FIFO raises `empty_n` on the second `rd_clk` rising edge after the write edge, and not on the first.
- R6: The write edge that stores the 64th word drives `full_n` to 0. Write attempts are ignored while `full_n` is 0. `full_n` returns to 1 once a read frees a location and the read pointer has crossed to the write side.
- R7: Read attempts while `empty_n` is 0 are ignored. `rd_data` does not change, and no word is consumed.
- R8: `afull_n` is 0 whenever the number of free locations is at or below X. For the block's own writes, it updates on the same write edge that stores the word.
- R9: `aempty_n` is 0 whenever the number of stored words, as seen on the read side, is at or below X.
- R10: The rising edge of `rst_n` captures `ofs_sel` and fixes X as follows: 2'b00 gives 16, 2'b01 gives 12, 2'b10 gives 8 and 2'b11 gives 4. Changes to `ofs_sel` after that edge have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; its rising edge latches `ofs_sel` |
| ofs_sel | input | 2 | Threshold preset select |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no location is free (write clock) |
| afull_n | output | 1 | Low when free locations are at or below X (write clock) |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when no word is stored (read clock) |
| aempty_n | output | 1 | Low when stored words are at or below X (read clock) |

## Verification
A wrong pointer shows up at the read port as a duplicated, skipped or stale word. The scoreboard catches it on the very read that returns the word. A bad pointer handover between the domains leaves a flag stuck, or makes it move one edge early or late. The bench therefore samples each flag at a fixed edge count after the event it reports. A wrong latched threshold moves the almost-full or almost-empty transition by at least four words, and the bench probes the level on both sides of the expected boundary.

// File: rtl/fifo_flag_pkg.sv
`timescale 1ns/1ps
package fifo_flag_pkg;

    typedef logic [1:0] ofs_code_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] r;
        r[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            r[i] = r[i+1] ^ g[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_re,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] out_d, out_q;

    always_ff @(posedge wr_clk) begin
        if (wr_we) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        out_d = out_q;
        if (rd_re) out_d = mem_q[rd_addr];
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data = out_q;
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl
    import fifo_flag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [PTR_W-1:0]  peer_gray_i,
    input  logic [PTR_W-1:0]  ofs_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [PTR_W-1:0]  gray_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              full_n_o,
    output logic              afull_n_o
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    typedef struct packed {
        logic             arm;
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic [PTR_W-1:0] peer_s1;
        logic             full_n;
        logic             afull_n;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic             do_wr;
    logic [PTR_W-1:0] peer_bin, used, free;

    always_comb begin
        st_d         = st_q;
        do_wr        = req && st_q.full_n;
        st_d.arm     = 1'b1;
        st_d.peer_s1 = peer_gray_i;
        st_d.bin     = st_q.bin + PTR_W'(do_wr);
        st_d.gray    = PTR_W'(bin2gray(32'(st_d.bin)));
        peer_bin     = PTR_W'(gray2bin(32'(st_q.peer_s1)));
        used         = st_d.bin - peer_bin;
        free         = DEPTH_P - used;
        st_d.full_n  = st_q.arm && (used != DEPTH_P);
        st_d.afull_n = st_q.arm && (free > ofs_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we_o      = do_wr;
    assign addr_o    = st_q.bin[ADDR_W-1:0];
    assign gray_o    = st_q.gray;
    assign ptr_o     = st_q.bin;
    assign full_n_o  = st_q.full_n;
    assign afull_n_o = st_q.afull_n;
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
    import fifo_flag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [PTR_W-1:0]  peer_gray_i,
    input  logic [PTR_W-1:0]  ofs_i,
    output logic              re_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [PTR_W-1:0]  gray_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              empty_n_o,
    output logic              aempty_n_o
);
    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic [PTR_W-1:0] peer_s1;
        logic             empty_n;
        logic             aempty_n;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic             do_rd;
    logic [PTR_W-1:0] peer_bin, used;

    always_comb begin
        st_d          = st_q;
        do_rd         = req && st_q.empty_n;
        st_d.peer_s1  = peer_gray_i;
        st_d.bin      = st_q.bin + PTR_W'(do_rd);
        st_d.gray     = PTR_W'(bin2gray(32'(st_d.bin)));
        peer_bin      = PTR_W'(gray2bin(32'(st_q.peer_s1)));
        used          = peer_bin - st_d.bin;
        st_d.empty_n  = (used != '0);
        st_d.aempty_n = (used > ofs_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign re_o       = do_rd;
    assign addr_o     = st_q.bin[ADDR_W-1:0];
    assign gray_o     = st_q.gray;
    assign ptr_o      = st_q.bin;
    assign empty_n_o  = st_q.empty_n;
    assign aempty_n_o = st_q.aempty_n;
endmodule

// File: rtl/dual_clock_flag_fifo.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo
    import fifo_flag_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6,
    parameter int OFS_C0 = 16,
    parameter int OFS_C1 = 12,
    parameter int OFS_C2 = 8,
    parameter int OFS_C3 = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_cs_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_cs_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PTR_W = ADDR_W + 1;

    ofs_code_t         ofs_code_q;
    logic [PTR_W-1:0]  ofs_x;
    logic              wr_we, rd_re;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_ptr_bin, rd_ptr_bin;

    // Threshold code is fixed by the release edge of reset.
    always_ff @(posedge rst_n) begin
        ofs_code_q <= ofs_sel;
    end

    always_comb begin
        unique case (ofs_code_q)
            2'd0:    ofs_x = PTR_W'(OFS_C0);
            2'd1:    ofs_x = PTR_W'(OFS_C1);
            2'd2:    ofs_x = PTR_W'(OFS_C2);
            default: ofs_x = PTR_W'(OFS_C3);
        endcase
    end

    fifo_wr_ctl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .req(!wr_cs_n && wr_en),
        .peer_gray_i(rd_gray), .ofs_i(ofs_x),
        .we_o(wr_we), .addr_o(wr_addr), .gray_o(wr_gray), .ptr_o(wr_ptr_bin),
        .full_n_o(full_n), .afull_n_o(afull_n)
    );

    fifo_rd_ctl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .req(!rd_cs_n && rd_en),
        .peer_gray_i(wr_gray), .ofs_i(ofs_x),
        .re_o(rd_re), .addr_o(rd_addr), .gray_o(rd_gray), .ptr_o(rd_ptr_bin),
        .empty_n_o(empty_n), .aempty_n_o(aempty_n)
    );

    fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .wr_we(wr_we), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_re(rd_re), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/dual_clock_flag_fifo_chk.sv
`timescale 1ns/1ps
module dual_clock_flag_fifo_chk #(
    parameter int DATA_W = 36,
    parameter int PTR_W  = 7
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_cs_n,
    input logic              wr_en,
    input logic              rd_cs_n,
    input logic              rd_en,
    input logic              full_n,
    input logic              afull_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_ptr
);
    always @(negedge wr_clk) begin
        if (!rst_n) begin
            AST_RST_WR_FLAGS: assert (!full_n && !afull_n); // R3
        end
    end

    always @(negedge rd_clk) begin
        if (!rst_n) begin
            AST_RST_RD_FLAGS: assert (!empty_n && !aempty_n); // R3
        end
    end

    AST_WR_QUALIFY: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_cs_n || !wr_en) |=> $stable(wr_ptr)); // R1

    AST_RD_QUALIFY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_cs_n || !rd_en) |=> $stable(rd_ptr)); // R1

    AST_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_cs_n || !rd_en || !empty_n) |=> $stable(rd_data)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wr_ptr)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_ptr)); // R7

    AST_FULL_IN_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n); // R8

    AST_EMPTY_IN_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n); // R9
endmodule

bind dual_clock_flag_fifo dual_clock_flag_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .rd_data(rd_data), .wr_ptr(wr_ptr_bin), .rd_ptr(rd_ptr_bin)
);

// File: tb/test_dual_clock_flag_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_flag_fifo;
    localparam int DW = 36;

    logic          wr_clk, rd_clk;
    logic          rst_n = 1'b1;
    logic [1:0]    ofs_sel = 2'b00;
    logic          wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full_n, afull_n, empty_n, aempty_n;

    int            n_checks = 0, n_fail = 0, seq = 0;
    logic [DW-1:0] sb[$];

    dual_clock_flag_fifo i_dual_clock_flag_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    initial begin wr_clk = 1'b0; forever #2.5 wr_clk = ~wr_clk; end
    initial begin rd_clk = 1'b0; #2; forever #2.5 rd_clk = ~rd_clk; end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Driver: each qualified attempt seen with full_n high becomes an expected item.
    task automatic wr_burst(input int n, input bit sel_n = 1'b0, input bit en = 1'b1);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_cs_n = sel_n; wr_en = en;
            wr_data = {seq[3:0], 32'hC0DE_0000 ^ seq[31:0]};
            seq++;
            if (!sel_n && en && full_n) sb.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic rd_burst(input int n, input bit sel_n = 1'b0);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk); #0.5;
            rd_cs_n = sel_n; rd_en = 1'b1;
        end
        @(negedge rd_clk); #0.5;
        rd_cs_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        check("R3 full_n", full_n, 0);
        check("R3 afull_n", afull_n, 0);
        check("R3 empty_n", empty_n, 0);
        check("R3 aempty_n", aempty_n, 0);
        sb.delete();
        ofs_sel = sel;
        @(negedge wr_clk);
        rst_n = 1'b1;
        @(negedge wr_clk);
        check("R4 full_n after first edge", full_n, 0);
        @(negedge wr_clk);
        check("R4 full_n after second edge", full_n, 1);
    endtask

    // Monitor: compares every accepted read against the scoreboard head.
    initial begin
        logic          e_prev = 1'b0;
        logic [DW-1:0] last_rd = '0;
        forever begin
            @(negedge rd_clk);
            if (!rd_cs_n && rd_en && e_prev) begin
                if (sb.size() == 0) check("R2 word without write", rd_data, 64'hDEAD);
                else                check("R2 word order", rd_data, sb.pop_front());
            end else if (!rd_cs_n && rd_en && rst_n) begin
                check("R7 rd_data held while empty", rd_data, last_rd);
            end else if (rd_cs_n && rd_en && rst_n) begin
                check("R1 rd_data held when deselected", rd_data, last_rd);
            end
            last_rd = rd_data;
            e_prev  = empty_n;
        end
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        summary();
    end

    initial begin
        #1 rst_n = 1'b0;
        do_reset(2'b00);
        check("R8 afull_n high when empty", afull_n, 1);

        // R5: empty_n rises on the second read edge after the write
        wr_burst(1);
        @(negedge rd_clk);
        check("R5 empty_n after first rd edge", empty_n, 0);
        @(negedge rd_clk);
        check("R5 empty_n after second rd edge", empty_n, 1);
        rd_burst(1);
        repeat (3) @(negedge rd_clk);
        check("R7 empty_n after drain", empty_n, 0);

        // R1: unqualified writes are ignored
        wr_burst(3, 1'b1, 1'b1);
        wr_burst(3, 1'b0, 1'b0);
        repeat (5) @(negedge rd_clk);
        check("R1 empty_n after ignored writes", empty_n, 0);

        // R1 read side, then R7 reads while empty
        wr_burst(1);
        repeat (4) @(negedge rd_clk);
        rd_burst(3, 1'b1);
        check("R1 empty_n after deselected reads", empty_n, 1);
        rd_burst(1);
        repeat (3) @(negedge rd_clk);
        rd_burst(3);
        wr_burst(2);
        repeat (4) @(negedge rd_clk);
        rd_burst(2);
        repeat (3) @(negedge rd_clk);
        check("R7 scoreboard empty", sb.size(), 0);

        // R8/R6 with X=16
        do_reset(2'b00);
        wr_burst(47);
        check("R8 afull_n at 17 free", afull_n, 1);
        wr_burst(1);
        check("R8 afull_n at 16 free", afull_n, 0);
        wr_burst(15);
        check("R6 full_n at 63 words", full_n, 1);
        wr_burst(1);
        check("R6 full_n at 64 words", full_n, 0);
        wr_burst(3);
        check("R6 queue holds 64", sb.size(), 64);
        rd_burst(1);
        repeat (4) @(negedge wr_clk);
        check("R6 full_n after one read", full_n, 1);
        rd_burst(63);
        repeat (4) @(negedge rd_clk);
        check("R6 no extra word stored", empty_n, 0);
        check("R6 scoreboard drained", sb.size(), 0);

        // R9 with X=16
        wr_burst(16);
        repeat (4) @(negedge rd_clk);
        check("R9 aempty_n at 16 words", aempty_n, 0);
        check("R9 empty_n at 16 words", empty_n, 1);
        wr_burst(1);
        repeat (4) @(negedge rd_clk);
        check("R9 aempty_n at 17 words", aempty_n, 1);
        rd_burst(17);

        // R10: code 11 gives X=4, later select changes ignored
        do_reset(2'b11);
        ofs_sel = 2'b00;
        wr_burst(4);
        repeat (4) @(negedge rd_clk);
        check("R10 aempty_n at 4 words X=4", aempty_n, 0);
        wr_burst(1);
        repeat (4) @(negedge rd_clk);
        check("R10 aempty_n at 5 words X=4", aempty_n, 1);
        wr_burst(54);
        check("R10 afull_n at 5 free X=4", afull_n, 1);
        wr_burst(1);
        check("R10 afull_n at 4 free X=4", afull_n, 0);
        rd_burst(60);

        // R10: code 10 gives X=8
        do_reset(2'b10);
        wr_burst(8);
        repeat (4) @(negedge rd_clk);
        check("R10 aempty_n at 8 words X=8", aempty_n, 0);
        wr_burst(1);
        repeat (4) @(negedge rd_clk);
        check("R10 aempty_n at 9 words X=8", aempty_n, 1);
        rd_burst(9);

        // R2: concurrent traffic
        fork
            wr_burst(40);
            rd_burst(50);
        join
        rd_burst(64);
        repeat (4) @(negedge rd_clk);
        check("R2 all words returned", sb.size(), 0);
        check("R2 empty after stream", empty_n, 0);

        summary();
    end
endmodule